// File: doc/BRIEF.md
# Byte-stream to bus-write command decoder

This block sits between a host link that delivers bytes one at a time and an on-chip bus master port that performs word writes. Bytes arrive through a valid/ready handshake. The block reads them as a framed command stream. Each frame starts with an opcode byte. Two opcodes are recognised, and each is followed by a four-byte payload sent least significant byte first:

- **Data frame:** the payload is assembled into a 32-bit word. That word is written to the address held in an internal address register. The register then advances by one.
- **Address frame:** the payload replaces the contents of the address register.

Any other opcode byte is dropped, and the decoder waits for the next opcode.

The write port holds a request, together with its address and data, until the target acknowledges it. While a write is outstanding the byte input stops accepting, so the host never has a byte discarded. A host therefore sets a start address once and can then stream words into consecutive locations.

Top module: `byte_cmd_writer`

## Requirements
- R1: After reset the address register is zero, the decoder waits for an opcode, `in_ready` is 1 and `wr_req` is 0.
- R2: Opcode 0x01 followed by bytes b0, b1, b2, b3 produces one write whose data is {b3,b2,b1,b0}; the bytes 0x78, 0x56, 0x34, 0x12 give 0x12345678.
- R3: A data write carries the current value of the address register on `wr_addr`.
- R4: Each completed write (the cycle with `wr_req` and `wr_ack` both 1) advances the address register by one, modulo 2^ADDR_W, so 0xFFFF is followed by 0x0000 when ADDR_W is 16.
- R5: Opcode 0x02 followed by four bytes, least significant first, loads the low ADDR_W bits of the assembled value into the address register, without causing a write.
- R6: A byte received while waiting for an opcode that is neither 0x01 nor 0x02 is consumed and dropped. It causes no write and leaves the address register unchanged.
- R7: `in_ready` is 0 in every cycle in which `wr_req` is 1, so no byte is consumed while a write is pending.
- R8: Once raised, `wr_req` stays at 1 with `wr_addr` and `wr_data` unchanged until the cycle in which `wr_ack` is 1, and falls in the following cycle; each data frame yields exactly one write.
- R9: No write request is made until the fourth payload byte of a data frame has been accepted; the request is raised in the cycle after that byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Host byte is present |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Block accepts the byte in this cycle |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | ADDR_W | Word address of the write |
| wr_data | output | WORD_W | Write data |
| wr_ack | input | 1 | Target accepts the pending write |

## Verification
The assertions assume the target raises `wr_ack` only while `wr_req` is high, and only for a single cycle per request. The bench's bus responder follows this. It acknowledges after a programmable wait of zero to three cycles and drops the acknowledge immediately afterwards.

Host bytes are presented at the falling edge and held until `in_ready` is seen high. The byte stream therefore never relies on a byte being taken while the port is stalled.

// File: rtl/bcw_pkg.sv
// Package: shared types for the byte-stream write command decoder.
// Assumes nothing beyond an 8-bit host byte.
package bcw_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_DATA   = 2'd1,
        ST_ADDR   = 2'd2,
        ST_WRITE  = 2'd3
    } bcw_state_e;

endpackage

// File: rtl/bcw_word_asm.sv
// Module: collects bytes, least significant first, into a word.
// Each shift places the new byte at the top and moves the older bytes down,
// so after WORD_W/8 shifts the first byte sits in the lowest lane.
// `last` flags that the next shift completes a word; the counter then wraps.
// Assumes WORD_W is a multiple of 8.
module bcw_word_asm #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic [7:0]        byte_in,
    output logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] word_next,
    output logic              last
);
    localparam int NBYTES = WORD_W / 8;
    localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [CNT_W-1:0] cnt;

    generate
        if (NBYTES > 1) begin : g_multi
            // Purpose: word value after the pending byte is inserted.
            always_comb word_next = {byte_in, word[WORD_W-1:8]};
        end else begin : g_single
            // Purpose: single-byte word takes the byte as is.
            always_comb word_next = byte_in;
        end
    endgenerate

    // Purpose: flag the final byte of a word.
    always_comb last = (cnt == CNT_W'(NBYTES - 1));

    // Purpose: shift the byte in and advance the byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else if (shift) begin
            word <= word_next;
            cnt  <= last ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bcw_addr_reg.sv
// Module: address register with direct load and post-increment.
// A load takes priority over an increment; the increment wraps modulo 2^ADDR_W.
module bcw_addr_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    // Purpose: hold, load or advance the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/byte_cmd_writer.sv
// Module: top of the byte-stream write command decoder.
// Opcode OP_DATA followed by a payload writes a word to the current address,
// which then advances by one. Opcode OP_ADDR followed by a payload loads the
// address. Other opcodes are dropped.
// Assumes ADDR_W <= WORD_W, and that wr_ack is high only while wr_req is high.
module byte_cmd_writer #(
    parameter int         WORD_W  = 32,
    parameter int         ADDR_W  = 16,
    parameter logic [7:0] OP_DATA = 8'h01,
    parameter logic [7:0] OP_ADDR = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ack
);
    import bcw_pkg::*;

    bcw_state_e        state, state_nx;
    logic              accept;
    logic              shift;
    logic              last;
    logic              addr_load;
    logic              addr_inc;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] word_next;

    // Purpose: handshake and datapath control decoded from the state.
    always_comb begin
        in_ready  = (state != ST_WRITE);
        accept    = in_valid && in_ready;
        shift     = accept && (state == ST_DATA || state == ST_ADDR);
        addr_load = shift && (state == ST_ADDR) && last;
        addr_inc  = (state == ST_WRITE) && wr_ack;
        wr_req    = (state == ST_WRITE);
    end

    // Purpose: frame sequencing from opcode through payload to bus write.
    always_comb begin
        state_nx = state;
        case (state)
            ST_OPCODE: if (accept) begin
                if (in_data == OP_DATA)      state_nx = ST_DATA;
                else if (in_data == OP_ADDR) state_nx = ST_ADDR;
            end
            ST_DATA:  if (shift && last) state_nx = ST_WRITE;
            ST_ADDR:  if (shift && last) state_nx = ST_OPCODE;
            ST_WRITE: if (wr_ack)        state_nx = ST_OPCODE;
            default:  state_nx = ST_OPCODE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OPCODE;
        else        state <= state_nx;
    end

    bcw_word_asm #(.WORD_W(WORD_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift     (shift),
        .byte_in   (in_data),
        .word      (word),
        .word_next (word_next),
        .last      (last)
    );

    bcw_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (word_next[ADDR_W-1:0]),
        .inc      (addr_inc),
        .addr     (wr_addr)
    );

    // Purpose: the payload is held in the assembler while the write is pending.
    always_comb wr_data = word;

endmodule

// File: rtl/bcw_chk.sv
// Module: protocol checker for byte_cmd_writer, attached through bind.
// Assumes the bus target acknowledges only a pending request.
module bcw_chk #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              wr_ack
);
    // R7
    no_byte_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !in_ready);

    // R8
    req_held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    // R8
    req_drops_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> !wr_req);

    // R4
    addr_post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    // R9
    req_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> $past(in_valid && in_ready));

endmodule

bind byte_cmd_writer bcw_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bcw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .wr_req   (wr_req),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_ack   (wr_ack)
);

// File: tb/tb_byte_cmd_writer.sv
// Bench: sweeps payload patterns, acknowledge latencies, address loads,
// every unknown opcode value and a partial frame; expected writes are
// computed from a bench-side address model.
module tb_byte_cmd_writer;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = 8'h00;
    logic              in_ready;
    logic              wr_req;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic              wr_ack = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    int lat    = 0;
    bit done   = 0;

    logic [ADDR_W-1:0] exp_a [0:1023];
    logic [WORD_W-1:0] exp_d [0:1023];
    int                q_wr = 0;
    int                q_rd = 0;
    logic [ADDR_W-1:0] model_addr = '0;

    always #4 clk = ~clk;

    byte_cmd_writer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] op, input logic [31:0] w);
        send_byte(op);
        for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
    endtask

    task automatic write_word(input logic [31:0] w);
        exp_a[q_wr] = model_addr;
        exp_d[q_wr] = w;
        q_wr++;
        model_addr = model_addr + 1'b1;
        send_frame(8'h01, w);
    endtask

    task automatic load_addr(input logic [31:0] a);
        model_addr = a[ADDR_W-1:0];
        send_frame(8'h02, a);
    endtask

    task automatic drain();
        while (q_rd != q_wr) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Bus responder: acknowledges after `lat` cycles and checks each write.
    initial begin
        int wcnt = 0;
        logic [ADDR_W-1:0] hold_a;
        logic [WORD_W-1:0] hold_d;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                wr_ack = 1'b0;
                wcnt   = 0;
            end else if (wr_ack) begin
                wr_ack = 1'b0;
            end else if (wr_req) begin
                chk(!in_ready, "R7 ready low while busy", 32'(in_ready), 32'd0);
                if (wcnt == 0) begin
                    hold_a = wr_addr;
                    hold_d = wr_data;
                end
                if (wcnt >= lat) begin
                    wr_ack = 1'b1;
                    wcnt   = 0;
                    chk(wr_addr == hold_a && wr_data == hold_d,
                        "R8 held stable", wr_data, hold_d);
                    if (q_rd >= q_wr) begin
                        chk(1'b0, "R6/R9 unexpected write", 32'(wr_addr), 32'hFFFFFFFF);
                    end else begin
                        chk(wr_addr == exp_a[q_rd], "R3 write address",
                            32'(wr_addr), 32'(exp_a[q_rd]));
                        chk(wr_data == exp_d[q_rd], "R2 write data",
                            wr_data, exp_d[q_rd]);
                        q_rd++;
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 32'd1);
        chk(wr_req == 1'b0, "R1 no request after reset", 32'(wr_req), 32'd0);
        chk(wr_addr == '0, "R1 address zero", 32'(wr_addr), 32'd0);

        // R2 byte order example, written to address 0 (R1, R3)
        write_word(32'h12345678);
        drain();

        // R9 and R7: request rises the cycle after the fourth byte is accepted
        lat = 3;
        send_byte(8'h01);
        send_byte(8'hA1);
        send_byte(8'hB2);
        send_byte(8'hC3);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'hD4;
        exp_a[q_wr] = model_addr;
        exp_d[q_wr] = 32'hD4C3B2A1;
        q_wr++;
        model_addr = model_addr + 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(wr_req == 1'b1, "R9 request after last byte", 32'(wr_req), 32'd1);
        chk(in_ready == 1'b0, "R7 ready low on request", 32'(in_ready), 32'd0);
        // a byte offered now is held off and taken later (R7)
        write_word(32'hCAFEF00D);
        drain();

        // R4 sweep of words across acknowledge latencies
        for (int l = 0; l < 4; l++) begin
            lat = l;
            for (int i = 0; i < 16; i++)
                write_word((32'h01010101 * i) ^ (32'(l) << 28) ^ {i[3:0], 28'h0ACE5A5});
            write_word(32'hFFFFFFFF);
            write_word(32'h00000000);
        end
        drain();
        chk(wr_addr == model_addr, "R4 address after sweep", 32'(wr_addr), 32'(model_addr));

        // R5 address loads: upper bits ignored, wrap at the top (R4)
        lat = 1;
        load_addr(32'h00ABCDEF);
        @(negedge clk);
        chk(wr_addr == 16'hCDEF, "R5 load low bits", 32'(wr_addr), 32'h0000CDEF);
        chk(q_rd == q_wr && !wr_req, "R5 load writes nothing", 32'(wr_req), 32'd0);
        write_word(32'h11112222);
        load_addr(32'h0000FFFF);
        write_word(32'h33334444);
        write_word(32'h55556666);
        drain();
        chk(wr_addr == 16'h0001, "R4 wrap to zero", 32'(wr_addr), 32'h1);

        // R6 every unknown opcode value is dropped
        lat = 0;
        for (int op = 0; op < 256; op++) begin
            if (op != 1 && op != 2) begin
                send_byte(8'(op));
                chk(!wr_req, "R6 no write from unknown opcode", 32'(wr_req), 32'd0);
            end
        end
        repeat (2) @(negedge clk);
        chk(wr_addr == model_addr, "R6 address unchanged", 32'(wr_addr), 32'(model_addr));
        chk(q_rd == q_wr, "R6 no extra writes", 32'(q_rd), 32'(q_wr));
        write_word(32'h0BADBEEF);
        drain();

        // R9 partial frame: three bytes never reach the bus
        send_byte(8'h01);
        send_byte(8'h10);
        send_byte(8'h20);
        send_byte(8'h30);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!wr_req, "R9 partial frame idle", 32'(wr_req), 32'd0);
        end
        exp_a[q_wr] = model_addr;
        exp_d[q_wr] = 32'h40302010;
        q_wr++;
        model_addr = model_addr + 1'b1;
        send_byte(8'h40);
        drain();

        chk(q_rd == q_wr, "R8 one write per data frame", 32'(q_rd), 32'(q_wr));
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule